// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block turns application interrupt requests into message writes for a few functions, each with a handful of vectors. Each function has its own configuration set. A configuration write sets the message enable, the exponent that fixes how many vectors the function may use, the message address, the base data word, the per-vector mask bits and a stored legacy interrupt-off flag.

The application raises a request for one function and vector, or asks to drop that vector's held interrupt. It keeps the request asserted until a one-cycle acknowledge arrives, which carries a two-bit outcome. A request on a masked vector is not lost: it is kept as a pending bit. Software sees that bit through a configuration read. When the vector is later unmasked, the held interrupt is released as one message, unless the application dropped it first.

Messages leave on a valid/ready stream that carries the address and the data word. The low bits of the data word encode the vector number.

Top module: `msi_vector_ctrl`

## Requirements
- R1: After reset the message stream is idle, the acknowledge is low, and every function reads back zero for its control, mask and pending registers.
- R2: A request on an unmasked, in-range vector of an enabled function produces exactly one message carrying that function's address. It is acknowledged with status 2'b00 in the same cycle the message becomes valid.
- R3: A request on a masked vector sends no message, sets that vector's pending bit and is acknowledged with status 2'b01.
- R4: A configuration read with select code 5 returns the selected function's pending bits, with bit v set when vector v is held.
- R5: A drop request (application clear flag high) resets the selected vector's pending bit to 0, sends nothing and is acknowledged with status 2'b11.
- R6: Unmasking a vector whose pending bit was dropped sends no message.
- R7: Unmasking a vector whose pending bit is still set emits exactly one message for it, and the pending bit then reads 0.
- R8: A request on a function whose enable bit is 0, or on a vector number not below 2^exponent, is acknowledged with status 2'b10. It sends no message and sets no pending bit.
- R9: The message data equals the function's programmed data word with its low `exponent` bits replaced by the vector number. The exponent is control bits 3:1 (enable is control bit 0), clamped to log2 of the vectors per function.
- R10: While valid is high and ready is low, valid stays high and address and data stay unchanged.
- R11: Bit 10 of the command register (select code 0) is stored and read back as the legacy interrupt-off flag, and does not stop messages. The other select codes are: 1 control, 2 address, 3 data, 4 mask (bit v masks vector v).
- R12: Held interrupts released by unmasking leave one per message, lowest function first and then lowest vector. A release takes precedence over a waiting application request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_func | input | FUNC_W | Function addressed by the write |
| cfg_wr_sel | input | 3 | Register select code of the write |
| cfg_wr_data | input | CFG_W | Write data |
| cfg_rd_func | input | FUNC_W | Function addressed by the read |
| cfg_rd_sel | input | 3 | Register select code of the read |
| cfg_rd_data | output | CFG_W | Combinational read data |
| app_req | input | 1 | Application request, held until acknowledged |
| app_clr | input | 1 | With app_req: drop the held interrupt instead of raising one |
| app_func | input | FUNC_W | Function of the request |
| app_vec | input | VEC_W | Vector of the request |
| app_ack | output | 1 | One-cycle acknowledge |
| app_status | output | 2 | Outcome: 00 sent, 01 held, 10 refused, 11 dropped |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | ADDR_W | Message address |
| msg_data | output | DATA_W | Message data |

## Verification
The assertions assume that the requester keeps app_req, app_clr, app_func and app_vec steady from the cycle it raises the request until the acknowledge, and drops the request after seeing it. They also assume that only functions that exist are addressed. The bench's request task drives each operation as one held handshake and releases it one edge after the acknowledge. Configuration writes and the ready input change only on falling edges, while no request is in flight.

// File: rtl/msi_ctrl_pkg.sv
package msi_ctrl_pkg;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_ADDR = 3'd2,
        SEL_DATA = 3'd3,
        SEL_MASK = 3'd4,
        SEL_PEND = 3'd5
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_SENT    = 2'b00,
        ST_HELD    = 2'b01,
        ST_REFUSED = 2'b10,
        ST_DROPPED = 2'b11
    } ack_status_e;

    localparam int INTDIS_BIT = 10;
    localparam int EN_BIT     = 0;
    localparam int CNT_LSB    = 1;
    localparam int CNT_W      = 3;

endpackage

// File: rtl/msi_func_cfg.sv
module msi_func_cfg
    import msi_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16,
    parameter int MAX_VEC = 8,
    parameter int CFG_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [CFG_W-1:0]    wr_data,
    output logic                msi_en,
    output logic [CNT_W-1:0]    cnt_exp,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   data,
    output logic [MAX_VEC-1:0]  mask,
    output logic                intdis
);

    localparam int VEC_W = $clog2(MAX_VEC);

    typedef struct packed {
        logic               intdis;
        logic               en;
        logic [CNT_W-1:0]   exp;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [MAX_VEC-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_CMD:  cfg_d.intdis = wr_data[INTDIS_BIT];
                SEL_CTRL: begin
                    cfg_d.en = wr_data[EN_BIT];
                    if (wr_data[CNT_LSB +: CNT_W] > CNT_W'(VEC_W))
                        cfg_d.exp = CNT_W'(VEC_W);
                    else
                        cfg_d.exp = wr_data[CNT_LSB +: CNT_W];
                end
                SEL_ADDR: cfg_d.addr = wr_data[ADDR_W-1:0];
                SEL_DATA: cfg_d.data = wr_data[DATA_W-1:0];
                SEL_MASK: cfg_d.mask = wr_data[MAX_VEC-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign msi_en  = cfg_q.en;
    assign cnt_exp = cfg_q.exp;
    assign addr    = cfg_q.addr;
    assign data    = cfg_q.data;
    assign mask    = cfg_q.mask;
    assign intdis  = cfg_q.intdis;

endmodule

// File: rtl/msi_pend_scan.sv
module msi_pend_scan #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/msi_msg_slot.sv
module msi_msg_slot #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              free
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    assign free = !slot_q.valid || out_ready;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = load_addr;
            slot_d.data  = load_data;
        end else if (slot_q.valid && out_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid = slot_q.valid;
    assign out_addr  = slot_q.addr;
    assign out_data  = slot_q.data;

endmodule

// File: rtl/msi_vector_ctrl.sv
module msi_vector_ctrl
    import msi_ctrl_pkg::*;
#(
    parameter int NUM_FUNC = 2,
    parameter int MAX_VEC  = 8,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 32,
    parameter int FUNC_W   = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
    parameter int VEC_W    = $clog2(MAX_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [FUNC_W-1:0] cfg_wr_func,
    input  logic [2:0]        cfg_wr_sel,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    input  logic [FUNC_W-1:0] cfg_rd_func,
    input  logic [2:0]        cfg_rd_sel,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              app_req,
    input  logic              app_clr,
    input  logic [FUNC_W-1:0] app_func,
    input  logic [VEC_W-1:0]  app_vec,
    output logic              app_ack,
    output logic [1:0]        app_status,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);

    localparam int NV    = NUM_FUNC * MAX_VEC;
    localparam int IDX_W = (NV > 1) ? $clog2(NV) : 1;

    typedef struct packed {
        logic [NV-1:0] pend;
        logic          ack;
        logic [1:0]    status;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              f_en     [NUM_FUNC];
    logic [CNT_W-1:0]  f_exp    [NUM_FUNC];
    logic [ADDR_W-1:0] f_addr   [NUM_FUNC];
    logic [DATA_W-1:0] f_data   [NUM_FUNC];
    logic [MAX_VEC-1:0] f_mask  [NUM_FUNC];
    logic              f_intdis [NUM_FUNC];

    logic [NV-1:0]     elig;
    logic              scan_found;
    logic [IDX_W-1:0]  scan_idx;
    logic              slot_free;
    logic              ld;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic [NV-1:0]     pend_bits;

    function automatic logic [DATA_W-1:0] fmt_data(input logic [DATA_W-1:0] base,
                                                   input logic [CNT_W-1:0] e,
                                                   input int v);
        logic [DATA_W-1:0] low;
        low = (DATA_W'(1) << e) - DATA_W'(1);
        return (base & ~low) | (DATA_W'(v) & low);
    endfunction

    // per-function configuration sets
    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_func
        msi_func_cfg #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .MAX_VEC(MAX_VEC),
            .CFG_W  (CFG_W)
        ) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_wr_en && (int'(cfg_wr_func) == g)),
            .wr_sel (cfg_wr_sel),
            .wr_data(cfg_wr_data),
            .msi_en (f_en[g]),
            .cnt_exp(f_exp[g]),
            .addr   (f_addr[g]),
            .data   (f_data[g]),
            .mask   (f_mask[g]),
            .intdis (f_intdis[g])
        );

        for (genvar v = 0; v < MAX_VEC; v++) begin : g_vec
            assign elig[g*MAX_VEC + v] = st_q.pend[g*MAX_VEC + v] && !f_mask[g][v]
                                         && f_en[g] && ((v >> f_exp[g]) == 0);
        end
    end

    msi_pend_scan #(.N(NV), .IDX_W(IDX_W)) u_scan (
        .cand (elig),
        .found(scan_found),
        .idx  (scan_idx)
    );

    msi_msg_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_addr(ld_addr),
        .load_data(ld_data),
        .out_ready(msg_ready),
        .out_valid(msg_valid),
        .out_addr (msg_addr),
        .out_data (msg_data),
        .free     (slot_free)
    );

    // arbitration: release of held vectors first, then the application
    always_comb begin
        int                rel_f;
        int                rel_v;
        logic [ADDR_W-1:0] rel_addr;
        logic [DATA_W-1:0] rel_dat;
        logic [CNT_W-1:0]  rel_exp;
        logic              req_fok;
        logic              req_en;
        logic              req_mask;
        logic [CNT_W-1:0]  req_exp;
        logic [ADDR_W-1:0] req_addr;
        logic [DATA_W-1:0] req_dat;
        logic [IDX_W-1:0]  req_idx;

        st_d     = st_q;
        st_d.ack = 1'b0;
        ld       = 1'b0;
        ld_addr  = '0;
        ld_data  = '0;

        rel_f    = int'(scan_idx) / MAX_VEC;
        rel_v    = int'(scan_idx) % MAX_VEC;
        rel_addr = '0;
        rel_dat  = '0;
        rel_exp  = '0;
        req_fok  = 1'b0;
        req_en   = 1'b0;
        req_mask = 1'b0;
        req_exp  = '0;
        req_addr = '0;
        req_dat  = '0;
        req_idx  = IDX_W'(int'(app_func) * MAX_VEC + int'(app_vec));

        for (int f = 0; f < NUM_FUNC; f++) begin
            if (f == rel_f) begin
                rel_addr = f_addr[f];
                rel_dat  = f_data[f];
                rel_exp  = f_exp[f];
            end
            if (f == int'(app_func)) begin
                req_fok  = 1'b1;
                req_en   = f_en[f];
                req_mask = f_mask[f][app_vec];
                req_exp  = f_exp[f];
                req_addr = f_addr[f];
                req_dat  = f_data[f];
            end
        end

        if (slot_free && scan_found) begin
            ld                  = 1'b1;
            ld_addr             = rel_addr;
            ld_data             = fmt_data(rel_dat, rel_exp, rel_v);
            st_d.pend[scan_idx] = 1'b0;
        end else if (app_req && !st_q.ack) begin
            if (app_clr) begin
                st_d.ack = 1'b1;
                if (req_fok) begin
                    st_d.pend[req_idx] = 1'b0;
                    st_d.status        = ST_DROPPED;
                end else begin
                    st_d.status = ST_REFUSED;
                end
            end else if (!req_fok || !req_en || ((int'(app_vec) >> req_exp) != 0)) begin
                st_d.ack    = 1'b1;
                st_d.status = ST_REFUSED;
            end else if (req_mask) begin
                st_d.ack           = 1'b1;
                st_d.status        = ST_HELD;
                st_d.pend[req_idx] = 1'b1;
            end else if (slot_free) begin
                st_d.ack    = 1'b1;
                st_d.status = ST_SENT;
                ld          = 1'b1;
                ld_addr     = req_addr;
                ld_data     = fmt_data(req_dat, req_exp, int'(app_vec));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // configuration read mux
    always_comb begin
        cfg_rd_data = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (int'(cfg_rd_func) == f) begin
                case (cfg_rd_sel)
                    SEL_CMD:  cfg_rd_data[INTDIS_BIT] = f_intdis[f];
                    SEL_CTRL: begin
                        cfg_rd_data[EN_BIT]            = f_en[f];
                        cfg_rd_data[CNT_LSB +: CNT_W]  = f_exp[f];
                    end
                    SEL_ADDR: cfg_rd_data[ADDR_W-1:0]  = f_addr[f];
                    SEL_DATA: cfg_rd_data[DATA_W-1:0]  = f_data[f];
                    SEL_MASK: cfg_rd_data[MAX_VEC-1:0] = f_mask[f];
                    SEL_PEND: cfg_rd_data[MAX_VEC-1:0] = st_q.pend[f*MAX_VEC +: MAX_VEC];
                    default:  ;
                endcase
            end
        end
    end

    assign pend_bits  = st_q.pend;
    assign app_ack    = st_q.ack;
    assign app_status = st_q.status;

endmodule

// File: rtl/msi_vector_ctrl_chk.sv
module msi_vector_ctrl_chk #(
    parameter int NUM_FUNC = 2,
    parameter int MAX_VEC  = 8,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int FUNC_W   = 1,
    parameter int VEC_W    = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         app_ack,
    input logic [1:0]                   app_status,
    input logic [FUNC_W-1:0]            app_func,
    input logic [VEC_W-1:0]             app_vec,
    input logic                         msg_valid,
    input logic                         msg_ready,
    input logic [ADDR_W-1:0]            msg_addr,
    input logic [DATA_W-1:0]            msg_data,
    input logic [NUM_FUNC*MAX_VEC-1:0]  pend
);

    localparam int NV = NUM_FUNC * MAX_VEC;
    localparam int IW = (NV > 1) ? $clog2(NV) : 1;

    logic [IW-1:0] sel_idx;
    logic          sel_pend;

    assign sel_idx  = IW'(int'(app_func) * MAX_VEC + int'(app_vec));
    assign sel_pend = pend[sel_idx];

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        app_ack |=> !app_ack);

    a_r2_sent_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ack && app_status == 2'b00) |-> msg_valid);

    a_r3_held_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ack && app_status == 2'b01) |-> sel_pend);

    a_r5_drop_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ack && app_status == 2'b11) |-> !sel_pend);

endmodule

bind msi_vector_ctrl msi_vector_ctrl_chk #(
    .NUM_FUNC(NUM_FUNC),
    .MAX_VEC (MAX_VEC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .FUNC_W  (FUNC_W),
    .VEC_W   (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .app_ack   (app_ack),
    .app_status(app_status),
    .app_func  (app_func),
    .app_vec   (app_vec),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .pend      (pend_bits)
);

// File: tb/tb_msi_vector_ctrl.sv
`timescale 1ns/1ps
module tb_msi_vector_ctrl;

    localparam int NF = 2;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [0:0]  cfg_wr_func = '0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [0:0]  cfg_rd_func = '0;
    logic [2:0]  cfg_rd_sel = '0;
    logic [31:0] cfg_rd_data;
    logic        app_req = 1'b0;
    logic        app_clr = 1'b0;
    logic [0:0]  app_func = '0;
    logic [2:0]  app_vec = '0;
    logic        app_ack;
    logic [1:0]  app_status;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr;
    logic [15:0] msg_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    msi_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_func(cfg_wr_func), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_func(cfg_rd_func), .cfg_rd_sel(cfg_rd_sel),
        .cfg_rd_data(cfg_rd_data), .app_req(app_req), .app_clr(app_clr),
        .app_func(app_func), .app_vec(app_vec), .app_ack(app_ack),
        .app_status(app_status), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(string tag, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    bit          m_en   [NF];
    int          m_exp  [NF];
    logic [31:0] m_addr [NF];
    logic [15:0] m_dat  [NF];
    bit          m_mask [NF][NV];
    bit          m_pend [NF][NV];
    bit          m_valid, m_ack;
    logic [31:0] m_oaddr;
    logic [15:0] m_odata;
    int          m_status;

    function automatic logic [15:0] expect_data(logic [15:0] base, int e, int v);
        int low = (1 << e) - 1;
        return 16'((int'(base) & ~low) | (v & low));
    endfunction

    always @(posedge clk) begin : model
        bit free, loaded, found;
        int cf, cv, f, v, e;
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                m_en[i] = 0; m_exp[i] = 0; m_addr[i] = 0; m_dat[i] = 0;
                for (int j = 0; j < NV; j++) begin m_mask[i][j] = 0; m_pend[i][j] = 0; end
            end
            m_valid = 0; m_ack = 0; m_status = 0; m_oaddr = 0; m_odata = 0;
        end else begin
            free = !m_valid || msg_ready;
            loaded = 0; found = 0; cf = 0; cv = 0;
            for (int i = 0; i < NF * NV; i++) begin
                f = i / NV; v = i % NV;
                if (!found && m_pend[f][v] && !m_mask[f][v] && m_en[f] && v < (1 << m_exp[f])) begin
                    found = 1; cf = f; cv = v;
                end
            end
            if (free && found) begin
                m_pend[cf][cv] = 0;
                m_oaddr = m_addr[cf];
                m_odata = expect_data(m_dat[cf], m_exp[cf], cv);
                loaded = 1;
                m_ack = 0;
            end else if (app_req && !m_ack) begin
                f = int'(app_func); v = int'(app_vec);
                m_ack = 1;
                if (app_clr) begin m_pend[f][v] = 0; m_status = 3; end
                else if (!m_en[f] || v >= (1 << m_exp[f])) m_status = 2;
                else if (m_mask[f][v]) begin m_pend[f][v] = 1; m_status = 1; end
                else if (free) begin
                    m_status = 0; loaded = 1;
                    m_oaddr = m_addr[f];
                    m_odata = expect_data(m_dat[f], m_exp[f], v);
                end else m_ack = 0;
            end else m_ack = 0;
            if (loaded) m_valid = 1;
            else if (m_valid && msg_ready) m_valid = 0;
            if (cfg_wr_en) begin
                f = int'(cfg_wr_func);
                case (cfg_wr_sel)
                    3'd1: begin
                        m_en[f] = cfg_wr_data[0];
                        e = int'(cfg_wr_data[3:1]);
                        m_exp[f] = (e > 3) ? 3 : e;
                    end
                    3'd2: m_addr[f] = cfg_wr_data;
                    3'd3: m_dat[f] = cfg_wr_data[15:0];
                    3'd4: for (int j = 0; j < NV; j++) m_mask[f][j] = cfg_wr_data[j];
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 msg_valid", msg_valid, m_valid);
            if (m_valid) begin
                chk("R2 msg_addr", msg_addr, m_oaddr);
                chk("R9 msg_data", msg_data, m_odata);
            end
            chk("R12 app_ack", app_ack, m_ack);
            if (m_ack) chk("R2 app_status", app_status, m_status);
        end
    end

    // accepted messages
    int hs_cnt = 0;
    logic [15:0] hs_data [$];
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            hs_cnt++;
            hs_data.push_back(msg_data);
        end
    end

    task automatic wr(int f, int sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_func = 1'(f); cfg_wr_sel = 3'(sel); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic rd(int f, int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_func = 1'(f); cfg_rd_sel = 3'(sel);
        #1 d = cfg_rd_data;
    endtask

    task automatic op(int f, int v, bit clr, output int st);
        @(negedge clk);
        app_req = 1; app_clr = clr; app_func = 1'(f); app_vec = 3'(v);
        @(negedge clk);
        while (app_ack !== 1'b1) @(negedge clk);
        st = int'(app_status);
        app_req = 0; app_clr = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int st, n;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 msg_valid", msg_valid, 0);
        chk("R1 app_ack", app_ack, 0);
        rd(0, 1, r); chk("R1 ctrl", r, 0);
        rd(0, 4, r); chk("R1 mask", r, 0);
        rd(1, 5, r); chk("R1 pending", r, 0);

        wr(0, 2, 32'h1000_0000); wr(0, 3, 32'h0000_ABC0); wr(0, 1, 32'h5);
        wr(1, 2, 32'h2000_0040); wr(1, 3, 32'h0000_1238); wr(1, 1, 32'hF);
        rd(1, 1, r); chk("R9 exponent clamp", r, 32'h7);

        // R2, R9
        op(0, 3, 0, st);
        chk("R2 status sent", st, 0);
        chk("R2 valid at ack", msg_valid, 1);
        chk("R2 address", msg_addr, 32'h1000_0000);
        chk("R9 data f0 v3", msg_data, 16'hABC3);
        op(1, 5, 0, st);
        chk("R9 data f1 v5", msg_data, 16'h123D);

        // R3, R4
        wr(0, 4, 32'h2);
        n = hs_cnt;
        op(0, 1, 0, st);
        chk("R3 status held", st, 1);
        idle(3);
        chk("R3 no message", hs_cnt, n);
        rd(0, 5, r); chk("R4 pending read", r, 32'h2);

        // R5, R6
        op(0, 1, 1, st);
        chk("R5 status dropped", st, 3);
        rd(0, 5, r); chk("R5 pending cleared", r, 0);
        wr(0, 4, 32'h0);
        idle(5);
        chk("R6 no message after unmask", hs_cnt, n);

        // R7, R12
        wr(1, 4, 32'h44);
        op(1, 6, 0, st); chk("R3 held f1 v6", st, 1);
        op(1, 2, 0, st); chk("R3 held f1 v2", st, 1);
        rd(1, 5, r); chk("R4 pending f1", r, 32'h44);
        n = hs_cnt;
        wr(1, 4, 32'h0);
        idle(5);
        chk("R7 two releases", hs_cnt, n + 2);
        if (hs_cnt == n + 2) begin
            chk("R12 first release", hs_data[n], 16'h123A);
            chk("R12 second release", hs_data[n+1], 16'h123E);
        end
        rd(1, 5, r); chk("R7 pending after release", r, 0);

        // R8
        n = hs_cnt;
        op(0, 4, 0, st); chk("R8 out of range", st, 2);
        wr(1, 1, 32'h6);
        op(1, 0, 0, st); chk("R8 disabled", st, 2);
        idle(3);
        chk("R8 no message", hs_cnt, n);
        rd(0, 5, r); chk("R8 no pending f0", r, 0);
        rd(1, 5, r); chk("R8 no pending f1", r, 0);

        // R10
        @(negedge clk); msg_ready = 0;
        op(0, 0, 0, st); chk("R10 sent while stalled", st, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 valid held", msg_valid, 1);
            chk("R10 data held", msg_data, 16'hABC0);
        end
        msg_ready = 1;
        idle(2);
        chk("R10 drained", msg_valid, 0);

        // R11
        wr(0, 0, 32'h400);
        rd(0, 0, r); chk("R11 intdis readback", r, 32'h400);
        op(0, 1, 0, st); chk("R11 messages still sent", st, 0);
        idle(3);
        finish_run();
    end

endmodule